// File: doc/BRIEF.md
# Idle-Mode Clock Gating Controller

This block decides which subsystem clock domains stop while the processor sits in idle. Software writes a small configuration word. Each stored bit picks whether one gated domain stops when idle begins. The domains are:

- a bus group, covering the local-bus bridge, DMA and traffic-controller clocks together;
- a peripheral domain;
- an OS-timer/auxiliary domain;
- a timer/watchdog domain.

Idle begins on a software idle request strobe or on a wait-for-interrupt indication. Idle ends on a wake event. The block drives one registered clock-enable per domain to downstream glitch-free gate cells. Those enables change only on the free-running reference clock.

At idle entry the configuration in force is captured. Software may rewrite the register during idle, but the enables do not move until the next entry. While the timer runs as a watchdog, its enable never drops.

Top module: `idle_clk_gate_ctrl`

## Requirements
- R1: After reset the configuration reads 0 and all four enables are 1.
- R2: A write stores bits 6, 2, 1 and 0 of the written word and reads them back in the same positions. Bits 7, 5, 4 and 3 always read 0, whatever is written.
- R3: On the clock edge that samples `sw_idle_req` or `wfi_req` high outside idle, each enable goes to 0 exactly when its bit is set. The bit-to-enable mapping is: bit 6 to `en_bus_grp`, bit 2 to `en_periph`, bit 1 to `en_ostimer`, bit 0 to `en_wdtimer`.
- R4: With all configuration bits clear, entering idle leaves every enable at 1.
- R5: A wake event sampled during idle ends idle, and all enables are 1 after that same edge.
- R6: When a wake event and an idle request are sampled together outside idle, idle is not entered and all enables stay 1.
- R7: While `wdog_mode` was sampled high at the previous edge, `en_wdtimer` is 1, regardless of bit 0.
- R8: A configuration write during idle leaves the enables unchanged until idle ends. The new value governs the next idle entry.
- R9: Idle requests sampled while already idle change no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| sw_idle_req | input | 1 | Software idle request strobe |
| wfi_req | input | 1 | Wait-for-interrupt indication |
| wake_evt | input | 1 | Wake event that ends idle |
| wdog_mode | input | 1 | Timer is running as a watchdog |
| en_bus_grp | output | 1 | Enable for bus bridge, DMA and traffic-controller clocks |
| en_periph | output | 1 | Enable for the peripheral clock |
| en_ostimer | output | 1 | Enable for the OS-timer and auxiliary clocks |
| en_wdtimer | output | 1 | Enable for the timer/watchdog clock |

## Verification
If the captured stop mask were wrong, a bad enable level would appear one edge after idle entry. A stuck idle flag would instead show as enables that fail to return high one edge after a wake event. A snapshot refreshed by a write during idle would make an enable move in mid-idle. Every idle entry is followed by a wake, so each of these faults appears within two cycles of the stimulus that exposes it. The bench sweeps every stop-bit combination, with and without watchdog mode, through both request sources.

// File: rtl/idle_gate_pkg.sv
package idle_gate_pkg;

  localparam int CFG_W   = 8;
  localparam int NUM_DOM = 4;

  // domain indices
  localparam int DOM_WDT = 0;
  localparam int DOM_OST = 1;
  localparam int DOM_PER = 2;
  localparam int DOM_BUS = 3;

  // configuration bit that controls each domain, indexed by domain
  localparam int DOM_POS [NUM_DOM] = '{0, 1, 2, 6};

  typedef logic [NUM_DOM-1:0] dom_vec_t;
  typedef logic [CFG_W-1:0]   cfg_word_t;

  // bits that are stored; all others read as zero
  function automatic cfg_word_t cfg_keep_mask();
    cfg_word_t m;
    m = '0;
    for (int d = 0; d < NUM_DOM; d++) m[DOM_POS[d]] = 1'b1;
    return m;
  endfunction

  // per-domain stop request from a configuration word
  function automatic dom_vec_t stop_from_cfg(cfg_word_t c);
    dom_vec_t v;
    for (int d = 0; d < NUM_DOM; d++) v[d] = c[DOM_POS[d]];
    return v;
  endfunction

  // enable vector for an idle state, captured stop mask and watchdog mode
  function automatic dom_vec_t enables_from(logic idle, dom_vec_t stop, logic wdog);
    dom_vec_t e;
    e = idle ? ~stop : '1;
    e[DOM_WDT] = e[DOM_WDT] | wdog;
    return e;
  endfunction

endpackage

// File: rtl/igc_cfg_reg.sv
module igc_cfg_reg
  import idle_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  cfg_word_t wdata,
  output cfg_word_t cfg_q
);

  localparam cfg_word_t KEEP = cfg_keep_mask();

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= wdata & KEEP;
  end

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q & ~KEEP) == '0);

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> cfg_q == ($past(wdata) & KEEP));

endmodule

// File: rtl/igc_idle_track.sv
module igc_idle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_idle_req,
  input  logic wfi_req,
  input  logic wake_evt,
  output logic idle_q,
  output logic idle_next,
  output logic entry_evt,
  output logic exit_evt
);

  logic any_req;

  assign any_req   = sw_idle_req | wfi_req;
  // wake has priority over a simultaneous request
  assign entry_evt = !idle_q && any_req && !wake_evt;
  assign exit_evt  = idle_q && wake_evt;

  always_comb begin
    idle_next = idle_q;
    if (entry_evt)     idle_next = 1'b1;
    else if (exit_evt) idle_next = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= 1'b0;
    else        idle_q <= idle_next;
  end

  assert_wake_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q && wake_evt) |=> !idle_q);

  assert_wake_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_q && wake_evt) |=> !idle_q);

  assert_idle_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q && !wake_evt) |=> idle_q);

endmodule

// File: rtl/igc_enable_gen.sv
module igc_enable_gen
  import idle_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cfg_word_t cfg_q,
  input  logic      idle_q,
  input  logic      idle_next,
  input  logic      entry_evt,
  input  logic      exit_evt,
  input  logic      wdog_mode,
  output dom_vec_t  en_q
);

  dom_vec_t snap_q, snap_next, en_next;

  // stop mask is captured only at idle entry
  assign snap_next = entry_evt ? stop_from_cfg(cfg_q) : snap_q;
  assign en_next   = enables_from(idle_next, snap_next, wdog_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_next;
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q[d] <= 1'b1;
      else        en_q[d] <= en_next[d];
    end
  end

  assert_wake_all_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |=> (&en_q));

  assert_out_of_idle_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_q && !entry_evt) |=> (&en_q));

  assert_wdog_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_mode |=> en_q[DOM_WDT]);

  assert_hold_in_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q && !exit_evt) |=> $stable(en_q[NUM_DOM-1:1]));

endmodule

// File: rtl/idle_clk_gate_ctrl.sv
module idle_clk_gate_ctrl
  import idle_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             sw_idle_req,
  input  logic             wfi_req,
  input  logic             wake_evt,
  input  logic             wdog_mode,
  output logic             en_bus_grp,
  output logic             en_periph,
  output logic             en_ostimer,
  output logic             en_wdtimer
);

  cfg_word_t cfg_q;
  logic      idle_q, idle_next, entry_evt, exit_evt;
  dom_vec_t  en_q;

  igc_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg_q (cfg_q)
  );

  igc_idle_track u_idle (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_idle_req (sw_idle_req),
    .wfi_req     (wfi_req),
    .wake_evt    (wake_evt),
    .idle_q      (idle_q),
    .idle_next   (idle_next),
    .entry_evt   (entry_evt),
    .exit_evt    (exit_evt)
  );

  igc_enable_gen u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_q     (cfg_q),
    .idle_q    (idle_q),
    .idle_next (idle_next),
    .entry_evt (entry_evt),
    .exit_evt  (exit_evt),
    .wdog_mode (wdog_mode),
    .en_q      (en_q)
  );

  assign cfg_rdata  = cfg_q;
  assign en_bus_grp = en_q[DOM_BUS];
  assign en_periph  = en_q[DOM_PER];
  assign en_ostimer = en_q[DOM_OST];
  assign en_wdtimer = en_q[DOM_WDT];

  assert_reset_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&en_q));

endmodule

// File: tb/idle_clk_gate_ctrl_tb.sv
module idle_clk_gate_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       sw_idle_req = 1'b0, wfi_req = 1'b0, wake_evt = 1'b0, wdog_mode = 1'b0;
  logic       en_bus_grp, en_periph, en_ostimer, en_wdtimer;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  idle_clk_gate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sw_idle_req(sw_idle_req), .wfi_req(wfi_req),
    .wake_evt(wake_evt), .wdog_mode(wdog_mode), .en_bus_grp(en_bus_grp),
    .en_periph(en_periph), .en_ostimer(en_ostimer), .en_wdtimer(en_wdtimer)
  );

  function automatic logic [3:0] en_now();
    return {en_bus_grp, en_periph, en_ostimer, en_wdtimer};
  endfunction

  // expected enables {bus,per,ost,wdt}, derived arithmetically from the word
  function automatic logic [3:0] exp_en(logic idle, logic [7:0] c, logic wd);
    logic [3:0] stop;
    stop = {c[6], c[2], c[1], c[0]};
    if (!idle) return 4'hF;
    return ~stop | {3'b000, wd};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // drive on negedge, one rising edge, sample 1 ns after it
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic prep();
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    prep(); cfg_we = 1'b1; cfg_wdata = v;
    tick();
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic enter_idle(input logic use_wfi);
    prep();
    if (use_wfi) wfi_req = 1'b1; else sw_idle_req = 1'b1;
    tick();
    @(negedge clk); wfi_req = 1'b0; sw_idle_req = 1'b0;
  endtask

  task automatic wake();
    prep(); wake_evt = 1'b1;
    tick();
    @(negedge clk); wake_evt = 1'b0;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(cfg_rdata == 8'h00, "R1 cfg", cfg_rdata, 8'h00);
    chk(en_now() == 4'hF, "R1 enables", {4'h0, en_now()}, 8'h0F);
    @(negedge clk); rst_n = 1'b1;
    tick();
    chk(en_now() == 4'hF, "R1 after release", {4'h0, en_now()}, 8'h0F);

    // R2 sweep of every written word
    for (int v = 0; v < 256; v++) begin
      write_cfg(8'(v));
      chk(cfg_rdata == (8'(v) & 8'h47), "R2 readback", cfg_rdata, 8'(v) & 8'h47);
    end

    // R3 / R4 / R5 / R7: every stop combination, both request sources, watchdog on/off
    for (int m = 0; m < 16; m++) begin
      for (int src = 0; src < 2; src++) begin
        for (int wd = 0; wd < 2; wd++) begin
          logic [7:0] c;
          c = {1'b1, m[3], 3'b111, m[2], m[1], m[0]};
          write_cfg(c);
          @(negedge clk); wdog_mode = wd[0];
          enter_idle(src[0]);
          chk(en_now() == exp_en(1'b1, c, wd[0]),
              (m == 0) ? "R4 no stop" : (wd ? "R7 wdog idle" : "R3 idle entry"),
              {4'h0, en_now()}, {4'h0, exp_en(1'b1, c, wd[0])});
          wake();
          chk(en_now() == 4'hF, "R5 wake", {4'h0, en_now()}, 8'h0F);
        end
      end
    end
    @(negedge clk); wdog_mode = 1'b0;

    // R6 wake and request together outside idle
    write_cfg(8'h47);
    prep(); wake_evt = 1'b1; sw_idle_req = 1'b1; wfi_req = 1'b1;
    tick();
    @(negedge clk); wake_evt = 1'b0; sw_idle_req = 1'b0; wfi_req = 1'b0;
    chk(en_now() == 4'hF, "R6 wake wins", {4'h0, en_now()}, 8'h0F);
    tick();
    chk(en_now() == 4'hF, "R6 still out", {4'h0, en_now()}, 8'h0F);

    // R8 write during idle held, applied at next entry
    write_cfg(8'h04);
    enter_idle(1'b0);
    chk(en_now() == 4'b1011, "R8 entry", {4'h0, en_now()}, 8'h0B);
    write_cfg(8'h43);
    tick();
    chk(en_now() == 4'b1011, "R8 held", {4'h0, en_now()}, 8'h0B);

    // R9 further requests while idle
    enter_idle(1'b1);
    chk(en_now() == 4'b1011, "R9 req ignored", {4'h0, en_now()}, 8'h0B);
    wake();
    chk(en_now() == 4'hF, "R8 wake", {4'h0, en_now()}, 8'h0F);
    enter_idle(1'b1);
    chk(en_now() == 4'b0100, "R8 new cfg applied", {4'h0, en_now()}, 8'h04);

    // R7 watchdog raised during idle
    @(negedge clk); wdog_mode = 1'b1;
    tick();
    chk(en_wdtimer == 1'b1, "R7 wdog raised", {7'h0, en_wdtimer}, 8'h01);
    chk(en_bus_grp == 1'b0, "R8 bus held", {7'h0, en_bus_grp}, 8'h00);
    wake();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule